// File: doc/BRIEF.md
# Coprocessor Load/Store Handshake Controller

This controller sits on the coprocessor side of a host core and paces multi-word coprocessor load and store instructions. It follows the host pipeline by watching an active-low fetch request. Each fetch moves the word on the instruction bus into a decode stage, and moves the decoded word into an execute stage. While a handled instruction is in execute, the controller drives a 2-bit handshake code. That code first busy-waits for a programmed number of cycles, then counts down through the word transfers, and then falls back to ABSENT.

The host's pass input and late-cancel input decide whether the instruction may take effect. If pass is low before the first accepted transfer cycle, the instruction is abandoned without leaving a trace. A late cancel during the first memory cycle throws the instruction away. Once a handshake cycle is accepted, the controller raises a transfer strobe in the following cycle together with the word index and the direction. The host paces the transfer strobe, so it has no ready input and no back-pressure: the data datapath must take or present one word in every cycle in which `xfer_valid` is high.

Instruction fields used by the controller:
- bits [27:25] = 3'b110 mark a coprocessor transfer.
- bits [11:8] carry the coprocessor number, which must equal `CP_ID`.
- bit 20 is 1 for a load and 0 for a store.
- bits [6:4] give the busy-wait count.
- bits [3:0] give the word count, where 0 is treated as 1.

Top module: `cpls_hs_ctrl`

## Requirements
- R1: During and straight after reset, `hs` is ABSENT (2'b00) and `commit` and `xfer_valid` are low.
- R2: The decode and execute stages advance only on a clock edge at which `fetch_n` is low. An instruction reaches execute on the second such edge after it was on the bus. A word on the bus while `fetch_n` is high is not captured.
- R3: An instruction whose bits [27:25] are not 3'b110, or whose bits [11:8] differ from `CP_ID`, gives ABSENT in execute.
- R4: A handled instruction first shows WAIT (2'b01) for exactly the number of cycles in bits [6:4], provided pass is high.
- R5: After the wait, `hs` shows GO (2'b10) while two or more words remain and LAST (2'b11) when one word remains. A word count of 0 behaves as 1, so it shows LAST directly.
- R6: Each accepted GO or LAST cycle gives one `xfer_valid` pulse in the next cycle. `xfer_idx` counts 0, 1, 2 and so on, and `xfer_load` equals bit 20.
- R7: `commit` pulses once, in the cycle after the first accepted handshake, when `late_cancel` is low.
- R8: `late_cancel` high in that first memory cycle suppresses `commit` and that cycle's transfer strobe. It also drops the instruction, so `hs` becomes ABSENT.
- R9: `late_cancel` in any later memory cycle has no effect on transfers or on `hs`.
- R10: `pass` low in execute before the first accepted cycle abandons the instruction: `hs` becomes ABSENT with no commit and no transfer.
- R11: After the LAST cycle is accepted, `hs` returns to ABSENT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_n | input | 1 | Latched host fetch request, active low |
| instr | input | IW (32) | Instruction bus |
| pass | input | 1 | Host condition pass, low on condition fail or interrupt |
| late_cancel | input | 1 | Cancel due to data abort of the preceding instruction |
| hs | output | 2 | Handshake code: 00 ABSENT, 01 WAIT, 10 GO, 11 LAST |
| commit | output | 1 | One-cycle pulse when the instruction becomes final |
| xfer_valid | output | 1 | One data word moves this cycle |
| xfer_load | output | 1 | Direction of the transfer: 1 load, 0 store |
| xfer_idx | output | CNT_W (4) | Index of the word being moved |

## Verification
The bench builds the controller with its default parameters: coprocessor number 5, a 4-bit word count and a 3-bit wait count. With these values, instructions with zero, one, two and three words and waits of 0 to 2 cycles exercise the count-down of the handshake, the zero-count rule and the first-memory-cycle cancel window. The same set covers a cancel arriving outside that window, abandonment during a busy-wait and during a first GO, and mismatches of the coprocessor number and of the instruction class.

// File: rtl/cpls_pkg.sv
package cpls_pkg;
  localparam int CPLS_IW     = 32;
  localparam int CPLS_CNT_W  = 4;
  localparam int CPLS_WAIT_W = 3;

  typedef enum logic [1:0] {
    HS_ABSENT = 2'b00,
    HS_WAIT   = 2'b01,
    HS_GO     = 2'b10,
    HS_LAST   = 2'b11
  } hs_e;
endpackage

// File: rtl/cpls_fetch_pipe.sv
module cpls_fetch_pipe #(
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_n,
  input  logic [IW-1:0] instr,
  output logic          adv,
  output logic          dec_v,
  output logic [IW-1:0] dec_ir
);
  // Decode stage register; execute stage lives in the sequencer.
  assign adv = !fetch_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_v  <= 1'b0;
      dec_ir <= '0;
    end else if (adv) begin
      dec_v  <= 1'b1;
      dec_ir <= instr;
    end
  end
endmodule

// File: rtl/cpls_decode.sv
module cpls_decode #(
  parameter int          IW     = 32,
  parameter int          CNT_W  = 4,
  parameter int          WAIT_W = 3,
  parameter logic [3:0]  CP_ID  = 4'd5
) (
  input  logic              v,
  input  logic [IW-1:0]     ir,
  output logic              ours,
  output logic              ld,
  output logic [CNT_W-1:0]  cnt,
  output logic [WAIT_W-1:0] wt
);
  localparam int CLS_LSB = 25;
  localparam int ID_LSB  = 8;
  localparam int LD_BIT  = 20;
  localparam int WT_LSB  = 4;

  logic [CNT_W-1:0] raw_cnt;

  assign raw_cnt = ir[CNT_W-1:0];
  assign ours = v && (ir[CLS_LSB+2:CLS_LSB] == 3'b110) && (ir[ID_LSB+3:ID_LSB] == CP_ID);
  assign ld   = ir[LD_BIT];
  assign wt   = ir[WT_LSB+WAIT_W-1:WT_LSB];
  // A zero count still moves one word.
  assign cnt  = (raw_cnt == '0) ? CNT_W'(1) : raw_cnt;
endmodule

// File: rtl/cpls_xfer_seq.sv
module cpls_xfer_seq
  import cpls_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              n_ours,
  input  logic              n_ld,
  input  logic [CNT_W-1:0]  n_cnt,
  input  logic [WAIT_W-1:0] n_wt,
  input  logic              pass,
  input  logic              late_cancel,
  output logic [1:0]        hs,
  output logic              commit,
  output logic              xfer_valid,
  output logic              xfer_load,
  output logic [CNT_W-1:0]  xfer_idx
);
  logic              act;
  logic              ld_q;
  logic [WAIT_W-1:0] wt_left;
  logic [CNT_W-1:0]  words;
  logic              started;
  logic              first_mem;
  logic              pend;
  logic [CNT_W-1:0]  idx;
  logic              cancel_now;
  hs_e               hs_c;

  assign cancel_now = first_mem && late_cancel;

  always_comb begin
    if (!act)                hs_c = HS_ABSENT;
    else if (wt_left != '0)  hs_c = HS_WAIT;
    else if (words > CNT_W'(1)) hs_c = HS_GO;
    else                     hs_c = HS_LAST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act       <= 1'b0;
      ld_q      <= 1'b0;
      wt_left   <= '0;
      words     <= '0;
      started   <= 1'b0;
      first_mem <= 1'b0;
      pend      <= 1'b0;
      idx       <= '0;
    end else begin
      pend      <= 1'b0;
      first_mem <= 1'b0;
      if (xfer_valid) idx <= idx + CNT_W'(1);
      if (adv) begin
        act     <= n_ours;
        ld_q    <= n_ld;
        wt_left <= n_wt;
        words   <= n_cnt;
        started <= 1'b0;
        idx     <= '0;
      end else if (cancel_now) begin
        act   <= 1'b0;
        words <= '0;
      end else if (act) begin
        if (!started && !pass) begin
          act <= 1'b0;
        end else if (wt_left != '0) begin
          wt_left <= wt_left - WAIT_W'(1);
        end else begin
          words     <= words - CNT_W'(1);
          pend      <= 1'b1;
          first_mem <= !started;
          started   <= 1'b1;
          if (words == CNT_W'(1)) act <= 1'b0;
        end
      end
    end
  end

  assign hs         = hs_c;
  assign xfer_valid = pend && !cancel_now;
  assign commit     = first_mem && !late_cancel;
  assign xfer_load  = ld_q;
  assign xfer_idx   = idx;
endmodule

// File: rtl/cpls_hs_ctrl.sv
module cpls_hs_ctrl
  import cpls_pkg::*;
#(
  parameter int         IW     = CPLS_IW,
  parameter int         CNT_W  = CPLS_CNT_W,
  parameter int         WAIT_W = CPLS_WAIT_W,
  parameter logic [3:0] CP_ID  = 4'd5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_n,
  input  logic [IW-1:0]    instr,
  input  logic             pass,
  input  logic             late_cancel,
  output logic [1:0]       hs,
  output logic             commit,
  output logic             xfer_valid,
  output logic             xfer_load,
  output logic [CNT_W-1:0] xfer_idx
);
  logic              adv;
  logic              dec_v;
  logic [IW-1:0]     dec_ir;
  logic              n_ours;
  logic              n_ld;
  logic [CNT_W-1:0]  n_cnt;
  logic [WAIT_W-1:0] n_wt;

  cpls_fetch_pipe #(.IW(IW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .fetch_n(fetch_n), .instr(instr),
    .adv(adv), .dec_v(dec_v), .dec_ir(dec_ir)
  );

  cpls_decode #(.IW(IW), .CNT_W(CNT_W), .WAIT_W(WAIT_W), .CP_ID(CP_ID)) u_dec (
    .v(dec_v), .ir(dec_ir), .ours(n_ours), .ld(n_ld), .cnt(n_cnt), .wt(n_wt)
  );

  cpls_xfer_seq #(.CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .n_ours(n_ours), .n_ld(n_ld), .n_cnt(n_cnt), .n_wt(n_wt),
    .pass(pass), .late_cancel(late_cancel),
    .hs(hs), .commit(commit), .xfer_valid(xfer_valid),
    .xfer_load(xfer_load), .xfer_idx(xfer_idx)
  );
endmodule

// File: rtl/cpls_chk.sv
module cpls_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fetch_n,
  input logic       pass,
  input logic [1:0] hs,
  input logic       commit,
  input logic       xfer_valid
);
  // R7
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  // R6
  xfer_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> ($past(hs) == 2'b10 || $past(hs) == 2'b11));

  // R11
  last_to_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs == 2'b11 && fetch_n) |=> (hs == 2'b00));

  // R10
  wait_abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs == 2'b01 && !pass && fetch_n) |=> (hs == 2'b00));

  // R2
  absent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs == 2'b00 && fetch_n) |=> (hs == 2'b00));
endmodule

bind cpls_hs_ctrl cpls_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_n(fetch_n), .pass(pass),
  .hs(hs), .commit(commit), .xfer_valid(xfer_valid)
);

// File: tb/test_cpls_hs_ctrl.sv
module test_cpls_hs_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_n = 1'b1;
  logic [31:0] instr = '0;
  logic        pass = 1'b0;
  logic        late_cancel = 1'b0;
  logic [1:0]  hs;
  logic        commit;
  logic        xfer_valid;
  logic        xfer_load;
  logic [3:0]  xfer_idx;

  int n_chk = 0;
  int n_bad = 0;
  logic [4:0] exp_q[$];

  localparam logic [1:0] AB = 2'b00, WT = 2'b01, GO = 2'b10, LS = 2'b11;

  always #2 clk = ~clk;

  cpls_hs_ctrl i_cpls_hs_ctrl (
    .clk(clk), .rst_n(rst_n), .fetch_n(fetch_n), .instr(instr),
    .pass(pass), .late_cancel(late_cancel), .hs(hs), .commit(commit),
    .xfer_valid(xfer_valid), .xfer_load(xfer_load), .xfer_idx(xfer_idx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic ld, input logic [3:0] cnt, input logic [2:0] wt,
                                      input logic [3:0] id, input logic [2:0] cls);
    return {4'b0, cls, 4'b0, ld, 8'b0, id, 1'b0, wt, cnt};
  endfunction

  task automatic cyc(input logic fn, input logic [31:0] ir, input logic ps, input logic lc);
    @(negedge clk);
    fetch_n = fn; instr = ir; pass = ps; late_cancel = lc;
    #1;
  endtask

  task automatic load(input logic [31:0] ir);
    cyc(1'b0, ir, 1'b1, 1'b0);
    cyc(1'b0, 32'h0, 1'b1, 1'b0);
  endtask

  task automatic expect_xfer(input logic ld, input logic [3:0] idx);
    exp_q.push_back({ld, idx});
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Monitor: compares every transfer strobe against the scoreboard queue (R6).
  always @(negedge clk) begin
    #1;
    if (rst_n && xfer_valid) begin
      if (exp_q.size() == 0) check("R6 unexpected transfer", {27'b0, xfer_load, xfer_idx}, 32'h0);
      else check("R6 transfer word", {27'b0, xfer_load, xfer_idx}, {27'b0, exp_q.pop_front()});
    end
  end

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    check("R1 hs in reset", hs, AB);
    check("R1 commit in reset", commit, 0);
    check("R1 xfer in reset", xfer_valid, 0);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1 hs after reset", hs, AB);

    // Store, 3 words, wait 2: R4 R5 R7 R11
    load(mk(1'b0, 4'd3, 3'd2, 4'd5, 3'b110));
    cyc(1'b1, 0, 1'b1, 1'b0); check("R4 wait cycle 1", hs, WT);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R4 wait cycle 2", hs, WT);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R5 go three left", hs, GO); expect_xfer(1'b0, 4'd0);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R5 go two left", hs, GO); check("R7 commit", commit, 1);
    expect_xfer(1'b0, 4'd1);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R5 last", hs, LS); check("R7 single commit", commit, 0);
    expect_xfer(1'b0, 4'd2);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R11 absent after last", hs, AB);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R11 stays absent", hs, AB);

    // Load with zero count: R5 R6 R7
    load(mk(1'b1, 4'd0, 3'd0, 4'd5, 3'b110));
    cyc(1'b1, 0, 1'b1, 1'b0); check("R5 zero count gives last", hs, LS); expect_xfer(1'b1, 4'd0);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R7 commit single word", commit, 1);
    check("R11 absent single word", hs, AB);

    // Abandon during busy-wait: R10
    load(mk(1'b0, 4'd2, 3'd1, 4'd5, 3'b110));
    cyc(1'b1, 0, 1'b0, 1'b0); check("R10 wait shown", hs, WT);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R10 abandoned", hs, AB); check("R10 no commit", commit, 0);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R10 still absent", hs, AB);

    // Abandon on first GO: R10
    load(mk(1'b0, 4'd2, 3'd0, 4'd5, 3'b110));
    cyc(1'b1, 0, 1'b0, 1'b0); check("R10 go shown", hs, GO);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R10 abandoned from go", hs, AB);
    check("R10 no commit from go", commit, 0);

    // Late cancel in first memory cycle: R8
    load(mk(1'b1, 4'd2, 3'd0, 4'd5, 3'b110));
    cyc(1'b1, 0, 1'b1, 1'b0); check("R8 go", hs, GO);
    cyc(1'b1, 0, 1'b1, 1'b1); check("R8 no commit", commit, 0); check("R8 no transfer", xfer_valid, 0);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R8 dropped", hs, AB);

    // Late cancel outside window: R9
    load(mk(1'b1, 4'd3, 3'd0, 4'd5, 3'b110));
    cyc(1'b1, 0, 1'b1, 1'b0); check("R9 go", hs, GO); expect_xfer(1'b1, 4'd0);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R9 commit", commit, 1); expect_xfer(1'b1, 4'd1);
    cyc(1'b1, 0, 1'b1, 1'b1); check("R9 last kept", hs, LS); check("R9 transfer kept", xfer_valid, 1);
    expect_xfer(1'b1, 4'd2);
    cyc(1'b1, 0, 1'b1, 1'b1); check("R9 final transfer kept", xfer_valid, 1);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R11 absent after cancel-free run", hs, AB);

    // Not handled: R3
    load(mk(1'b0, 4'd2, 3'd0, 4'd6, 3'b110));
    cyc(1'b1, 0, 1'b1, 1'b0); check("R3 id mismatch", hs, AB);
    load(mk(1'b0, 4'd2, 3'd0, 4'd5, 3'b111));
    cyc(1'b1, 0, 1'b1, 1'b0); check("R3 class mismatch", hs, AB);

    // Pipeline advance only on fetch: R2
    cyc(1'b1, mk(1'b0, 4'd2, 3'd0, 4'd5, 3'b110), 1'b1, 1'b0);
    cyc(1'b0, 32'h0, 1'b1, 1'b0);
    cyc(1'b0, mk(1'b0, 4'd2, 3'd0, 4'd5, 3'b110), 1'b1, 1'b0);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R2 uncaptured word absent", hs, AB);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R2 decode waits for fetch", hs, AB);
    cyc(1'b0, 0, 1'b1, 1'b0);
    cyc(1'b1, 0, 1'b0, 1'b0); check("R2 reaches execute on second fetch", hs, GO);
    cyc(1'b1, 0, 1'b1, 1'b0); check("R10 abandon after R2 check", hs, AB);

    cyc(1'b1, 0, 1'b1, 1'b0);
    check("R6 all transfers seen", exp_q.size(), 0);
    report();
  end
endmodule